// File: doc/BRIEF.md
# Speculative Cache Line State Tracker

This block keeps the coherence state and the speculation flags for every line of a small direct-mapped cache that runs one speculative thread epoch at a time. Each line sits in one of six coherence states: Invalid, Shared, Exclusive, Dirty, and speculative variants of Shared and Exclusive. Each line also carries a spec-read flag and a spec-written flag. Local speculative loads and stores raise these flags. An invalidation arriving from an earlier epoch on a line this epoch has already read signals a dependence violation.

When the epoch becomes non-speculative, a one-cycle commit pulse turns all speculative state into ordinary state in a single step. A squash pulse throws it away in the same way. Written lines that were held only in a shared state are reported as a bitmap, so the surrounding logic can obtain exclusive ownership before the commit. Line fills are refused while the target line still carries a speculation flag, and the requester keeps the fill pending until the refusal clears.

Top module: `spec_line_tracker`

## Requirements
- R1: After reset every line is Invalid (state code 0), all spec-read, spec-written and ownership bits are 0, and `viol_o` is 0. State codes are: 0 Invalid, 1 Shared, 2 Exclusive, 3 Dirty, 4 spec-Shared, 5 spec-Exclusive, read from `line_state_o[3*i +: 3]`.
- R2: A load to a present line sets its spec-read bit on the next edge. Shared becomes spec-Shared, Exclusive becomes spec-Exclusive, and Dirty, spec-Shared and spec-Exclusive keep their state.
- R3: A store to a present line sets its spec-written bit. Shared and spec-Shared become or stay spec-Shared and set the line's bit in `own_req_o`. Exclusive, Dirty and spec-Exclusive become or stay spec-Exclusive without that bit. An ownership bit is never set unless the line's spec-written bit is also set.
- R4: A load or store to an Invalid line changes nothing.
- R5: An invalidation to a line that is not Invalid, whose spec-read bit is set, and whose `inv_earlier_i` is 1 drives `viol_o` high in the cycle after. No other invalidation raises it.
- R6: An invalidation to a line with neither flag set makes it Invalid. A line with either flag set keeps its state and flags.
- R7: `fill_blocked_o` is high in the same cycle when `fill_valid_i` targets a line with either flag set, and that line is left unchanged. Otherwise the fill installs the line as Exclusive (`fill_excl_i`=1) or Shared with flags clear.
- R8: On `commit_i`, every spec-written line becomes Dirty, every other spec-Shared line becomes Shared and every other spec-Exclusive line becomes Exclusive. All flags and ownership bits clear in that same edge.
- R9: On `squash_i`, every spec-written line becomes Invalid, spec-Shared reverts to Shared and spec-Exclusive to Exclusive. All flags and ownership bits clear in that same edge.
- R10: On one line, an unblocked fill is applied first. After that the order is squash, then commit, then invalidation, then local access. A load or store that coincides with commit or squash is dropped.
- R11: `viol_o` is never high two cycles in a row, and an invalidation that coincides with `squash_i` raises no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid_i | input | 1 | Local speculative access request |
| acc_store_i | input | 1 | Access is a store (1) or a load (0) |
| acc_idx_i | input | IDXW | Line index of the access |
| inv_valid_i | input | 1 | External invalidation |
| inv_idx_i | input | IDXW | Line index of the invalidation |
| inv_earlier_i | input | 1 | Sender epoch is logically earlier |
| fill_valid_i | input | 1 | Line replacement / fill request |
| fill_idx_i | input | IDXW | Line index of the fill |
| fill_excl_i | input | 1 | Install as Exclusive (1) or Shared (0) |
| commit_i | input | 1 | Epoch commit pulse |
| squash_i | input | 1 | Epoch squash pulse |
| viol_o | output | 1 | Dependence violation pulse |
| fill_blocked_o | output | 1 | Fill refused; request must be held |
| own_req_o | output | NLINES | Lines needing exclusive ownership at commit |
| line_state_o | output | 3*NLINES | Per-line state codes |
| sl_o | output | NLINES | Per-line spec-read bits |
| sm_o | output | NLINES | Per-line spec-written bits |

## Verification
The bench builds the tracker with NLINES=4 and not the default of 16. Random streams of loads, stores, invalidations and fills then hit the same few lines again and again. That makes same-line collisions between fill, invalidation, access, commit and squash common rather than rare, and it lets flags build up on several lines before each bulk commit or squash. Directed sequences then cover each state transition and the suppression of a violation by a simultaneous squash.

// File: rtl/stlt_pkg.sv
package stlt_pkg;

  typedef enum logic [2:0] {
    LS_I   = 3'd0,
    LS_S   = 3'd1,
    LS_E   = 3'd2,
    LS_D   = 3'd3,
    LS_SPS = 3'd4,
    LS_SPE = 3'd5
  } lstate_e;

  // state after a local speculative access to a present line
  function automatic lstate_e f_after_access(lstate_e st, logic store);
    case (st)
      LS_S:    return LS_SPS;
      LS_E:    return LS_SPE;
      LS_D:    return store ? LS_SPE : LS_D;
      default: return st;
    endcase
  endfunction

  // store into a shared-only holding needs ownership later
  function automatic logic f_needs_own(lstate_e st, logic store);
    return store && (st == LS_S || st == LS_SPS);
  endfunction

  function automatic lstate_e f_after_commit(lstate_e st, logic sm);
    if (sm && st != LS_I) return LS_D;
    case (st)
      LS_SPS:  return LS_S;
      LS_SPE:  return LS_E;
      default: return st;
    endcase
  endfunction

  function automatic lstate_e f_after_squash(lstate_e st, logic sm);
    if (sm) return LS_I;
    case (st)
      LS_SPS:  return LS_S;
      LS_SPE:  return LS_E;
      default: return st;
    endcase
  endfunction

endpackage

// File: rtl/stlt_line.sv
module stlt_line
  import stlt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    squash_i,
  input  logic    commit_i,
  input  logic    inv_hit_i,
  input  logic    acc_hit_i,
  input  logic    acc_store_i,
  input  logic    fill_hit_i,
  input  logic    fill_excl_i,
  output lstate_e st_o,
  output logic    sl_o,
  output logic    sm_o,
  output logic    own_o,
  output logic    busy_o
);

  lstate_e st_q, st_d;
  logic    sl_q, sl_d, sm_q, sm_d, own_q, own_d;

  // named events for the assertions
  logic fill_take, acc_take;
  assign busy_o    = sl_q | sm_q;
  assign fill_take = fill_hit_i && !busy_o;
  assign acc_take  = acc_hit_i && (st_q != LS_I) && !squash_i && !commit_i && !inv_hit_i;

  always_comb begin
    st_d  = st_q;
    sl_d  = sl_q;
    sm_d  = sm_q;
    own_d = own_q;
    if (fill_take) begin
      st_d  = fill_excl_i ? LS_E : LS_S;
      sl_d  = 1'b0;
      sm_d  = 1'b0;
      own_d = 1'b0;
    end else if (squash_i) begin
      st_d  = f_after_squash(st_q, sm_q);
      sl_d  = 1'b0;
      sm_d  = 1'b0;
      own_d = 1'b0;
    end else if (commit_i) begin
      st_d  = f_after_commit(st_q, sm_q);
      sl_d  = 1'b0;
      sm_d  = 1'b0;
      own_d = 1'b0;
    end else if (inv_hit_i) begin
      if (!busy_o) st_d = LS_I;
    end else if (acc_take) begin
      st_d = f_after_access(st_q, acc_store_i);
      if (acc_store_i) sm_d = 1'b1;
      else             sl_d = 1'b1;
      if (f_needs_own(st_q, acc_store_i)) own_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= LS_I;
      sl_q  <= 1'b0;
      sm_q  <= 1'b0;
      own_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      sl_q  <= sl_d;
      sm_q  <= sm_d;
      own_q <= own_d;
    end
  end

  assign st_o  = st_q;
  assign sl_o  = sl_q;
  assign sm_o  = sm_q;
  assign own_o = own_q;

  a_r3_own_needs_sm: assert property (@(posedge clk) disable iff (!rst_n)
    own_q |-> sm_q);

  a_r4_miss_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LS_I && acc_hit_i && !fill_hit_i) |=> (st_q == LS_I && !sl_q && !sm_q));

  a_r6_plain_inv: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_hit_i && !busy_o && !fill_hit_i && !squash_i && !commit_i) |=> (st_q == LS_I));

  a_r7_blocked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_hit_i && busy_o && !squash_i && !commit_i && !inv_hit_i && !acc_hit_i)
    |=> (st_q == $past(st_q) && sl_q == $past(sl_q) && sm_q == $past(sm_q)));

  a_r8_commit_settles: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !squash_i) |=> (!sl_q && !sm_q && !own_q && st_q != LS_SPS && st_q != LS_SPE));

  a_r9_squash_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (squash_i && sm_q) |=> (st_q == LS_I && !sm_q));

endmodule

// File: rtl/stlt_viol.sv
module stlt_viol (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic squash_i,
  output logic pulse_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) pulse_o <= 1'b0;
    else        pulse_o <= evt_i && !squash_i && !pulse_o;
  end

  a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);

  a_r11_squash_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    squash_i |=> !pulse_o);

endmodule

// File: rtl/spec_line_tracker.sv
module spec_line_tracker
  import stlt_pkg::*;
#(
  parameter int NLINES = 16,
  parameter int IDXW   = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_valid_i,
  input  logic                  acc_store_i,
  input  logic [IDXW-1:0]       acc_idx_i,
  input  logic                  inv_valid_i,
  input  logic [IDXW-1:0]       inv_idx_i,
  input  logic                  inv_earlier_i,
  input  logic                  fill_valid_i,
  input  logic [IDXW-1:0]       fill_idx_i,
  input  logic                  fill_excl_i,
  input  logic                  commit_i,
  input  logic                  squash_i,
  output logic                  viol_o,
  output logic                  fill_blocked_o,
  output logic [NLINES-1:0]     own_req_o,
  output logic [3*NLINES-1:0]   line_state_o,
  output logic [NLINES-1:0]     sl_o,
  output logic [NLINES-1:0]     sm_o
);

  lstate_e           st_w [NLINES];
  logic [NLINES-1:0] busy_w;
  logic              viol_evt;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic inv_hit, acc_hit, fill_hit;
    assign inv_hit  = inv_valid_i  && (inv_idx_i  == IDXW'(i));
    assign acc_hit  = acc_valid_i  && (acc_idx_i  == IDXW'(i));
    assign fill_hit = fill_valid_i && (fill_idx_i == IDXW'(i));

    stlt_line u_line (
      .clk         (clk),
      .rst_n       (rst_n),
      .squash_i    (squash_i),
      .commit_i    (commit_i),
      .inv_hit_i   (inv_hit),
      .acc_hit_i   (acc_hit),
      .acc_store_i (acc_store_i),
      .fill_hit_i  (fill_hit),
      .fill_excl_i (fill_excl_i),
      .st_o        (st_w[i]),
      .sl_o        (sl_o[i]),
      .sm_o        (sm_o[i]),
      .own_o       (own_req_o[i]),
      .busy_o      (busy_w[i])
    );

    assign line_state_o[3*i +: 3] = st_w[i];
  end

  assign fill_blocked_o = fill_valid_i && busy_w[fill_idx_i];
  assign viol_evt = inv_valid_i && inv_earlier_i &&
                    (st_w[inv_idx_i] != LS_I) && sl_o[inv_idx_i];

  stlt_viol u_viol (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (viol_evt),
    .squash_i (squash_i),
    .pulse_o  (viol_o)
  );

  a_r5_viol_origin: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |-> $past(inv_valid_i && inv_earlier_i));

  a_r7_block_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    fill_blocked_o |-> (sl_o[fill_idx_i] || sm_o[fill_idx_i]));

endmodule

// File: tb/sim_spec_line_tracker.sv
`timescale 1ns/100ps
module sim_spec_line_tracker;
  localparam int N = 4;
  localparam int W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic av = 0, as_ = 0, iv = 0, ie = 0, fv = 0, fe = 0, cm = 0, sq = 0;
  logic [W-1:0] ai = 0, ii = 0, fi = 0;
  logic viol, blk;
  logic [N-1:0] own, sl, sm;
  logic [3*N-1:0] lst;

  int checks = 0, errors = 0;
  int mst[N];
  bit msl[N], msm[N], mown[N];
  bit mviol = 0;

  always #2.5 clk = ~clk;

  spec_line_tracker #(.NLINES(N)) u0 (
    .clk(clk), .rst_n(rst_n),
    .acc_valid_i(av), .acc_store_i(as_), .acc_idx_i(ai),
    .inv_valid_i(iv), .inv_idx_i(ii), .inv_earlier_i(ie),
    .fill_valid_i(fv), .fill_idx_i(fi), .fill_excl_i(fe),
    .commit_i(cm), .squash_i(sq),
    .viol_o(viol), .fill_blocked_o(blk), .own_req_o(own),
    .line_state_o(lst), .sl_o(sl), .sm_o(sm)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int st_of(int i);
    return int'(lst[3*i +: 3]);
  endfunction

  task automatic compare_all();
    for (int i = 0; i < N; i++) begin
      chk($sformatf("R2 state line %0d", i), st_of(i), mst[i]);
      chk($sformatf("R2 spec-read line %0d", i), int'(sl[i]), int'(msl[i]));
      chk($sformatf("R3 spec-written line %0d", i), int'(sm[i]), int'(msm[i]));
      chk($sformatf("R3 ownership line %0d", i), int'(own[i]), int'(mown[i]));
    end
    chk("R5 violation", int'(viol), int'(mviol));
  endtask

  // one clock: drive at negedge, check fill refusal, advance model at edge
  task automatic cyc(bit a_v, bit a_s, int a_i, bit i_v, int i_i, bit i_e,
                     bit f_v, int f_i, bit f_e, bit c, bit s);
    int  nst[N];
    bit  nsl[N], nsm[N], nown[N];
    bit  nviol, exp_blk;
    @(negedge clk);
    av = a_v; as_ = a_s; ai = W'(a_i);
    iv = i_v; ii = W'(i_i); ie = i_e;
    fv = f_v; fi = W'(f_i); fe = f_e;
    cm = c; sq = s;
    #1;
    exp_blk = f_v && (msl[f_i] || msm[f_i]);
    chk("R7 fill refused", int'(blk), int'(exp_blk));
    nviol = i_v && i_e && mst[i_i] != 0 && msl[i_i] && !s && !mviol;
    for (int i = 0; i < N; i++) begin
      bit busy;
      busy = msl[i] || msm[i];
      nst[i] = mst[i]; nsl[i] = msl[i]; nsm[i] = msm[i]; nown[i] = mown[i];
      if (f_v && f_i == i && !busy) begin
        nst[i] = f_e ? 2 : 1;
      end else if (s) begin
        if (msm[i]) nst[i] = 0;
        else if (mst[i] == 4) nst[i] = 1;
        else if (mst[i] == 5) nst[i] = 2;
        nsl[i] = 0; nsm[i] = 0; nown[i] = 0;
      end else if (c) begin
        if (msm[i]) nst[i] = 3;
        else if (mst[i] == 4) nst[i] = 1;
        else if (mst[i] == 5) nst[i] = 2;
        nsl[i] = 0; nsm[i] = 0; nown[i] = 0;
      end else if (i_v && i_i == i) begin
        if (!busy) nst[i] = 0;
      end else if (a_v && a_i == i && mst[i] != 0) begin
        if (a_s) begin
          nsm[i] = 1;
          if (mst[i] == 1 || mst[i] == 4) begin nst[i] = 4; nown[i] = 1; end
          else nst[i] = 5;
        end else begin
          nsl[i] = 1;
          if (mst[i] == 1) nst[i] = 4;
          else if (mst[i] == 2) nst[i] = 5;
        end
      end
    end
    @(posedge clk);
    #1;
    for (int i = 0; i < N; i++) begin
      mst[i] = nst[i]; msl[i] = nsl[i]; msm[i] = nsm[i]; mown[i] = nown[i];
    end
    mviol = nviol;
    compare_all();
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic fill(int i, bit ex);
    cyc(0, 0, 0, 0, 0, 0, 1, i, ex, 0, 0);
  endtask
  task automatic acc(int i, bit st);
    cyc(1, st, i, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic inval(int i, bit e);
    cyc(0, 0, 0, 1, i, e, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin mst[i] = 0; msl[i] = 0; msm[i] = 0; mown[i] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 states", int'(lst), 0);
    chk("R1 flags", int'({sl, sm, own}), 0);
    chk("R1 violation", int'(viol), 0);

    fill(0, 0); fill(1, 1); fill(2, 1); fill(3, 0);
    chk("R7 fill shared", st_of(0), 1);
    chk("R7 fill excl", st_of(1), 2);
    acc(0, 0);
    chk("R2 load S->spec-Shared", st_of(0), 4);
    acc(1, 1);
    chk("R3 store E->spec-Excl", st_of(1), 5);
    chk("R3 no ownership for E", int'(own[1]), 0);
    acc(3, 1);
    chk("R3 ownership for S store", int'(own[3]), 1);
    fill(0, 1);
    chk("R7 blocked line kept", st_of(0), 4);
    inval(0, 0);
    chk("R5 later epoch no violation", int'(viol), 0);
    chk("R6 flagged line kept", st_of(0), 4);
    inval(2, 1);
    chk("R6 plain line invalidated", st_of(2), 0);
    acc(2, 0);
    chk("R4 miss ignored", int'(sl[2]), 0);
    inval(0, 1);
    chk("R5 violation raised", int'(viol), 1);
    idle();
    chk("R11 pulse ends", int'(viol), 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R8 read-only spec-Shared -> S", st_of(0), 1);
    chk("R8 written spec-Excl -> D", st_of(1), 3);
    chk("R8 written spec-Shared -> D", st_of(3), 3);
    chk("R8 ownership cleared", int'(own), 0);

    acc(0, 0); acc(1, 1); fill(2, 1); acc(2, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R9 spec-Shared -> S", st_of(0), 1);
    chk("R9 written line -> I", st_of(1), 0);
    chk("R9 spec-Excl -> E", st_of(2), 2);

    acc(0, 0);
    cyc(0, 0, 0, 1, 0, 1, 0, 0, 0, 0, 1);
    chk("R11 squash suppresses violation", int'(viol), 0);
    idle();
    chk("R11 still quiet after squash", int'(viol), 0);

    cyc(1, 1, 2, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R10 access dropped on commit", int'(sm[2]), 0);
    acc(2, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    chk("R10 squash beats commit", st_of(2), 0);
    fill(2, 0);
    acc(2, 0);
    cyc(1, 1, 2, 1, 2, 1, 0, 0, 0, 0, 0);
    chk("R10 invalidation beats access", int'(sm[2]), 0);

    for (int k = 0; k < 4000; k++) begin
      cyc($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, N - 1),
          ($urandom_range(0, 5) == 0), $urandom_range(0, N - 1), $urandom_range(0, 1),
          ($urandom_range(0, 3) == 0), $urandom_range(0, N - 1), $urandom_range(0, 1),
          ($urandom_range(0, 39) == 0), ($urandom_range(0, 49) == 0));
    end
    idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule